// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table from memory. The virtual address is cut into a 10-bit directory index in bits [31:22], a 10-bit table index in bits [21:12] and a 12-bit byte offset in bits [11:0]. The walker first reads a directory entry at the root pointer plus four times the directory index. If that entry is marked valid, it reads a leaf entry from the 4 KB table the entry names. It then either returns the leaf frame joined with the untouched offset, or reports a page fault.

The root pointer selects the active address space. It is a register that loads only when the writer is in kernel mode. The walker works on one translation at a time. It holds `busy` from the cycle after it accepts a request up to and including the cycle in which the one-cycle response is given. It talks to memory through a single read port. A read is issued as a one-cycle pulse, and the walker waits any number of cycles for the returning data.

Top module: `ptw_walker`

## Requirements
- R1: A successful walk returns `rsp_paddr` = {leaf entry bits [31:12], virtual address bits [11:0]} with `rsp_fault` low.
- R2: The first memory read of a walk is at root + 4 × vaddr[31:22].
- R3: The second memory read is at (directory entry bits [31:12] << 12) + 4 × vaddr[21:12].
- R4: An entry holds its frame number in bits [31:12] and its valid flag in bit 0. A directory entry with bit 0 clear ends the walk after exactly one read, with `rsp_fault` high and `rsp_paddr` zero.
- R5: A leaf entry with bit 0 clear gives `rsp_fault` high and `rsp_paddr` zero, after two reads.
- R6: A request (`req_valid` while `busy` is low) is accepted on that clock edge. `busy` then stays high through the response cycle, and `req_valid` asserted while busy is ignored.
- R7: `rsp_valid` is high for exactly one cycle per accepted request, and `busy` is low in the following cycle.
- R8: A root write with `root_wr_en` and `root_wr_kernel` both high loads `root_wr_data`. A write with `root_wr_kernel` low leaves the root unchanged.
- R9: A walk uses the root value held at the edge where its request is accepted. A root write in that same cycle, or during the walk, affects only later walks.
- R10: After reset, `busy`, `rsp_valid` and `mem_req` are low and the root pointer is zero.
- R11: `mem_req` lasts one cycle, occurs only while busy, and the walker waits any number of cycles for `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| busy | output | 1 | Walk in progress; requests are ignored |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Page fault indication |
| root_wr_en | input | 1 | Root pointer write strobe |
| root_wr_kernel | input | 1 | Writer is in kernel mode |
| root_wr_data | input | 32 | New root pointer value |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Returned table entry |

## Verification
An address-space switch and the acceptance of a new request can fall on the same clock edge. The bench provokes this by raising `req_valid` and a kernel root write on the same falling edge, while the old and new roots map the same virtual address to different frames. The result must carry the frame from the old root's tables, and the next walk must carry the frame from the new root's tables. A root write issued in the middle of a walk is judged the same way.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W       = 32;
    localparam int IDX_W      = 10;
    localparam int OFF_W      = 12;
    localparam int PTE_BYTES  = 4;
    localparam int PTE_SHIFT  = $clog2(PTE_BYTES);
    localparam int FRAME_W    = VA_W - OFF_W;
    localparam int IDX_PAD_W  = VA_W - IDX_W - PTE_SHIFT;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        logic [IDX_W-1:0] dir_idx;
        logic [IDX_W-1:0] tbl_idx;
        logic [OFF_W-1:0] offset;
    } vaddr_t;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [OFF_W-2:0]   spare;
        logic               valid;
    } pte_t;

    // Byte address of one entry inside a table starting at base.
    function automatic logic [VA_W-1:0] entry_addr(input logic [VA_W-1:0] base,
                                                   input logic [IDX_W-1:0] idx);
        return base + {{IDX_PAD_W{1'b0}}, idx, {PTE_SHIFT{1'b0}}};
    endfunction

    // Byte address of the first byte of a frame.
    function automatic logic [VA_W-1:0] frame_base(input logic [FRAME_W-1:0] frame);
        return {frame, {OFF_W{1'b0}}};
    endfunction

endpackage

// File: rtl/ptw_root_reg.sv
module ptw_root_reg
    import ptw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            wr_kernel,
    input  logic [VA_W-1:0] wr_data,
    output logic [VA_W-1:0] root_q
);

    // Only a privileged writer may switch address space.
    always_ff @(posedge clk) begin
        if (rst) begin
            root_q <= '0;
        end else if (wr_en && wr_kernel) begin
            root_q <= wr_data;
        end
    end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic               leaf_level,
    input  logic [VA_W-1:0]    root_snap,
    input  vaddr_t             va,
    input  logic [FRAME_W-1:0] dir_frame,
    output logic [VA_W-1:0]    rd_addr
);

    logic [VA_W-1:0] dir_addr;
    logic [VA_W-1:0] leaf_addr;

    always_comb begin
        dir_addr  = entry_addr(root_snap, va.dir_idx);
        leaf_addr = entry_addr(frame_base(dir_frame), va.tbl_idx);
        rd_addr   = leaf_level ? leaf_addr : dir_addr;
    end

endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [VA_W-1:0]    root_q,
    input  logic               mem_rvalid,
    input  logic [VA_W-1:0]    mem_rdata,
    output logic               busy,
    output logic               rsp_valid,
    output logic [VA_W-1:0]    rsp_paddr,
    output logic               rsp_fault,
    output logic               mem_req,
    output logic               leaf_level,
    output logic [VA_W-1:0]    root_snap,
    output vaddr_t             va_q,
    output logic [FRAME_W-1:0] dir_frame
);

    walk_state_e     state;
    pte_t            entry;
    logic [VA_W-1:0] paddr_q;
    logic            fault_q;
    logic            pte_unused;

    assign entry      = pte_t'(mem_rdata);
    assign pte_unused = ^entry.spare;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            va_q      <= '0;
            root_snap <= '0;
            dir_frame <= '0;
            paddr_q   <= '0;
            fault_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q      <= vaddr_t'(req_vaddr);
                        root_snap <= root_q;
                        state     <= ST_L1_REQ;
                    end
                end
                ST_L1_REQ: state <= ST_L1_WAIT;
                ST_L1_WAIT: begin
                    if (mem_rvalid) begin
                        if (entry.valid) begin
                            dir_frame <= entry.frame;
                            state     <= ST_L2_REQ;
                        end else begin
                            paddr_q <= '0;
                            fault_q <= 1'b1;
                            state   <= ST_DONE;
                        end
                    end
                end
                ST_L2_REQ: state <= ST_L2_WAIT;
                ST_L2_WAIT: begin
                    if (mem_rvalid) begin
                        if (entry.valid) begin
                            paddr_q <= {entry.frame, va_q.offset};
                            fault_q <= 1'b0;
                        end else begin
                            paddr_q <= '0;
                            fault_q <= 1'b1;
                        end
                        state <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = (state != ST_IDLE);
        rsp_valid  = (state == ST_DONE);
        rsp_paddr  = paddr_q;
        rsp_fault  = fault_q;
        mem_req    = (state == ST_L1_REQ) || (state == ST_L2_REQ);
        leaf_level = (state == ST_L2_REQ);
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    output logic        busy,
    output logic        rsp_valid,
    output logic [31:0] rsp_paddr,
    output logic        rsp_fault,
    input  logic        root_wr_en,
    input  logic        root_wr_kernel,
    input  logic [31:0] root_wr_data,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata
);

    logic [VA_W-1:0]    root_q;
    logic [VA_W-1:0]    root_snap;
    vaddr_t             va_q;
    logic [FRAME_W-1:0] dir_frame;
    logic               leaf_level;

    ptw_root_reg u_root (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (root_wr_en),
        .wr_kernel (root_wr_kernel),
        .wr_data   (root_wr_data),
        .root_q    (root_q)
    );

    ptw_walk_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_vaddr  (req_vaddr),
        .root_q     (root_q),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .rsp_valid  (rsp_valid),
        .rsp_paddr  (rsp_paddr),
        .rsp_fault  (rsp_fault),
        .mem_req    (mem_req),
        .leaf_level (leaf_level),
        .root_snap  (root_snap),
        .va_q       (va_q),
        .dir_frame  (dir_frame)
    );

    ptw_addr_gen u_addr (
        .leaf_level (leaf_level),
        .root_snap  (root_snap),
        .va         (va_q),
        .dir_frame  (dir_frame),
        .rd_addr    (mem_addr)
    );

endmodule

// File: rtl/ptw_walker_checker.sv
module ptw_walker_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic        busy,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic        rsp_fault,
    input logic        mem_req
);

    logic [31:0] cap_va;
    logic [1:0]  reads;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_va <= '0;
            reads  <= '0;
        end else if (req_valid && !busy) begin
            cap_va <= req_vaddr;
            reads  <= '0;
        end else if (mem_req && reads != 2'd3) begin
            reads <= reads + 2'd1;
        end
    end

    a_r6_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    a_r7_rsp_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r7_rsp_inside_busy: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> busy);

    a_r7_idle_after_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !busy);

    a_r11_req_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    a_r11_req_while_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[11:0] == cap_va[11:0]));

    a_r5_two_reads_on_hit: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (reads == 2'd2));

    a_r4_fault_zero_addr: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'h0));

endmodule

bind ptw_walker ptw_walker_checker u_chk (.*);

// File: tb/ptw_walker_test.sv
module ptw_walker_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        busy;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        root_wr_en = 1'b0;
    logic        root_wr_kernel = 1'b0;
    logic [31:0] root_wr_data = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ptw_walker uut (.*);

    // Memory model with variable read latency.
    logic [31:0] mem_model [logic [31:0]];
    int          lat = 1;
    int          cnt = 0;
    bit          pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int          read_count = 0;
    int          rsp_count = 0;
    logic [31:0] last_addr = '0;
    logic [31:0] prev_addr = '0;

    function automatic logic [31:0] lookup(input logic [31:0] a);
        return mem_model.exists(a) ? mem_model[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rst) begin
            pend <= 1'b0;
        end else begin
            if (mem_req) begin
                pend       <= 1'b1;
                cnt        <= lat - 1;
                pend_addr  <= mem_addr;
                read_count <= read_count + 1;
                prev_addr  <= last_addr;
                last_addr  <= mem_addr;
            end else if (pend) begin
                if (cnt == 0) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= lookup(pend_addr);
                    pend       <= 1'b0;
                end else begin
                    cnt <= cnt - 1;
                end
            end
            if (rsp_valid) rsp_count <= rsp_count + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_root(input logic [31:0] val, input logic kern);
        @(negedge clk);
        root_wr_en = 1'b1; root_wr_kernel = kern; root_wr_data = val;
        @(negedge clk);
        root_wr_en = 1'b0; root_wr_kernel = 1'b0;
    endtask

    task automatic wait_rsp(output logic [31:0] pa, output logic f);
        int guard = 0;
        while (!rsp_valid && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        pa = rsp_paddr;
        f  = rsp_fault;
        @(negedge clk);
    endtask

    task automatic walk(input logic [31:0] va, output logic [31:0] pa, output logic f);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        wait_rsp(pa, f);
    endtask

    // Vector: {vaddr, expected paddr, expected fault} with root 0x0001_0000.
    localparam logic [64:0] VECS [6] = '{
        {32'h0040_0123, 32'hABCD_E123, 1'b0},
        {32'h0040_5FFF, 32'h1234_5FFF, 1'b0},
        {32'h0040_7000, 32'h0000_0000, 1'b1},
        {32'h0080_0010, 32'h0000_0000, 1'b1},
        {32'hFFFF_FABC, 32'hFFFF_FABC, 1'b0},
        {32'h0000_0000, 32'h0000_0000, 1'b1}
    };

    initial begin
        logic [31:0] pa;
        logic        f;
        int          rc;
        int          rsps;

        // Space A: root 0x10000.
        mem_model[32'h0001_0004] = 32'h0002_0001;
        mem_model[32'h0001_0008] = 32'h0003_0000;
        mem_model[32'h0001_0FFC] = 32'h0003_0001;
        mem_model[32'h0002_0000] = 32'hABCD_E001;
        mem_model[32'h0002_0014] = 32'h1234_5001;
        mem_model[32'h0002_001C] = 32'h9999_9000;
        mem_model[32'h0003_0FFC] = 32'hFFFF_F001;
        // Space B: root 0x50000.
        mem_model[32'h0005_0004] = 32'h0006_0001;
        mem_model[32'h0006_0000] = 32'h7777_7001;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state.
        chk("R10 busy", {31'b0, busy}, 32'h0);
        chk("R10 rsp_valid", {31'b0, rsp_valid}, 32'h0);
        chk("R10 mem_req", {31'b0, mem_req}, 32'h0);
        // R10 root is zero: the first read lands at 0 + 4*idx.
        walk(32'h0040_0000, pa, f);
        chk("R10 root zero read addr", last_addr, 32'h0000_0004);
        chk("R10 R4 fault from empty table", {31'b0, f}, 32'h1);

        set_root(32'h0001_0000, 1'b1);

        // Vector table at two memory latencies.
        for (int pass = 0; pass < 2; pass++) begin
            lat = (pass == 0) ? 1 : 4;
            for (int i = 0; i < 6; i++) begin
                walk(VECS[i][64:33], pa, f);
                chk("R1 R4 R5 R11 paddr", pa, VECS[i][32:1]);
                chk("R1 R4 R5 R11 fault", {31'b0, f}, {31'b0, VECS[i][0]});
            end
        end
        lat = 2;

        // R2, R3: read addresses of a two-level walk.
        walk(32'h0040_5FFF, pa, f);
        chk("R2 directory read addr", prev_addr, 32'h0001_0004);
        chk("R3 leaf read addr", last_addr, 32'h0002_0014);

        // R4: directory fault stops after one read.
        rc = read_count;
        walk(32'h0080_0010, pa, f);
        chk("R4 single read on directory fault", read_count - rc, 1);
        chk("R4 fault paddr zero", pa, 32'h0);

        // R5: leaf fault after two reads.
        rc = read_count;
        walk(32'h0040_7000, pa, f);
        chk("R5 two reads on leaf fault", read_count - rc, 2);
        chk("R5 fault flag", {31'b0, f}, 32'h1);

        // R8: user-mode root write is ignored.
        set_root(32'h0005_0000, 1'b0);
        walk(32'h0040_0123, pa, f);
        chk("R8 user write ignored", pa, 32'hABCD_E123);

        // R8: kernel-mode write switches space.
        set_root(32'h0005_0000, 1'b1);
        walk(32'h0040_0123, pa, f);
        chk("R8 kernel write switches space", pa, 32'h7777_7123);

        // R9: root write in the acceptance cycle uses the old root.
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0040_0123;
        root_wr_en = 1'b1; root_wr_kernel = 1'b1; root_wr_data = 32'h0001_0000;
        @(negedge clk);
        req_valid = 1'b0; root_wr_en = 1'b0; root_wr_kernel = 1'b0;
        wait_rsp(pa, f);
        chk("R9 same-cycle write uses old root", pa, 32'h7777_7123);
        walk(32'h0040_0123, pa, f);
        chk("R9 next walk uses new root", pa, 32'hABCD_E123);

        // R9: root write in the middle of a walk.
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0040_0123;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        root_wr_en = 1'b1; root_wr_kernel = 1'b1; root_wr_data = 32'h0005_0000;
        @(negedge clk);
        root_wr_en = 1'b0; root_wr_kernel = 1'b0;
        wait_rsp(pa, f);
        chk("R9 mid-walk write not seen", pa, 32'hABCD_E123);
        walk(32'h0040_0123, pa, f);
        chk("R9 mid-walk write seen later", pa, 32'h7777_7123);
        set_root(32'h0001_0000, 1'b1);

        // R6, R7: request held during a busy walk is ignored.
        lat  = 4;
        rsps = rsp_count;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0040_0123;
        @(negedge clk);
        chk("R6 busy after accept", {31'b0, busy}, 32'h1);
        req_vaddr = 32'h0080_0010;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        wait_rsp(pa, f);
        chk("R6 first request result kept", pa, 32'hABCD_E123);
        chk("R7 busy low after response", {31'b0, busy}, 32'h0);
        repeat (3) @(negedge clk);
        chk("R6 R7 one response only", rsp_count - rsps, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule